// File: doc/BRIEF.md
# Open-Drain Two-Line Pad Control Register

This block is a single memory-mapped register that lets software bit-bang a two-wire serial bus (a clock line and a data line) through open-drain pads. Each line carries a direction field and an output-value field. Each field has its own write-enable mask bit, so one write can change one field of one line and leave every other field as it was. The pad pulls low only when its line is set to output with value 0. In every other case the pad is released and the external pull-up raises the wire.

Each pad level passes through a two-flop synchroniser and is returned in a read-only bit of the register. Two pull-up disable bits are stored as plain register bits. They are rewritten on every write, whatever the masks say, and they drive the pad pull-up controls. The bus protocol itself, with its start, stop, bit timing and acknowledge, is carried out entirely by software toggling these fields.

Top module: `gpio_od_pad_reg`

## Requirements
- R1: While reset is held and after it is released with no write, both directions read as input (0), both values read 0, both `line_drive_low_o` bits are 0 and both `pullup_dis_o` bits are 0 (pull-ups enabled).
- R2: Line k (0 = clock, 1 = data) uses register bits 8k+0 = direction mask, 8k+1 = direction (1 = output), 8k+2 = value mask, 8k+3 = value. The direction bit is loaded only when its direction mask is 1 in the same write, and the value bit is loaded only when its value mask is 1.
- R3: A write with all four mask bits at 0 leaves the direction and value of both lines unchanged, whatever the direction and value bits of that write hold.
- R4: A write with direction = 1, value = 0 and both masks of line k set makes `line_drive_low_o[k]` 1 from the clock edge that accepts the write.
- R5: A write with direction = 0 and the direction mask of line k set releases the line: `line_drive_low_o[k]` becomes 0 and the stored value of that line is kept.
- R6: `line_drive_low_o[k]` is 1 exactly when line k is output with value 0. An output line with value 1 is not driven.
- R7: A write that sets mask bits of one line only does not change the fields or the pad control of the other line.
- R8: Bits 16 (clock line) and 17 (data line) are the pull-up disable bits. Every accepted write loads them from the written data, independent of all mask bits, and they appear on `pullup_dis_o` from the next clock edge.
- R9: Bit 8k+4 is read-only and returns `line_in_i[k]` after two flops: a level change becomes visible in the register exactly two rising edges after it reaches the input.
- R10: On read, the mask bit positions and all unassigned bits return 0. Direction, value and pull-up bits return their stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle it is high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Register read value (combinational from state) |
| line_in_i | input | 2 | Pad input levels, bit 0 clock line, bit 1 data line |
| line_drive_low_o | output | 2 | Pad pull-down enable per line, 1 pulls the wire low |
| pullup_dis_o | output | 2 | Pad pull-up disable per line |

## Verification
Field and pull-up updates are due at the rising edge that samples the write strobe. The bench raises the strobe on a falling edge, drops it on the next falling edge and reads the register and pad outputs there, one edge after the write. Input levels are due two rising edges after they change. The bench changes `line_in_i` on a falling edge, reads after one rising edge to confirm the old level is still shown, and reads after the second to confirm the new one. Every read compares the whole 32-bit word with a bench model, which also covers the bits that must read zero.

// File: rtl/gpio_od_pkg.sv
package gpio_od_pkg;
  localparam int unsigned LINES      = 2;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned OFS_DMSK   = 0;
  localparam int unsigned OFS_DIR    = 1;
  localparam int unsigned OFS_VMSK   = 2;
  localparam int unsigned OFS_VAL    = 3;
  localparam int unsigned OFS_IN     = 4;
  localparam int unsigned PUD_BASE   = 16;

  typedef struct packed {
    logic dir;  // 1 = output
    logic val;
  } line_cfg_t;
endpackage

// File: rtl/gpio_line_ctrl.sv
module gpio_line_ctrl
  import gpio_od_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  logic      dir_msk_i,
  input  logic      dir_i,
  input  logic      val_msk_i,
  input  logic      val_i,
  output line_cfg_t cfg_o,
  output logic      drive_low_o
);
  line_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      if (dir_msk_i) cfg_q.dir <= dir_i;
      if (val_msk_i) cfg_q.val <= val_i;
    end
  end

  assign cfg_o       = cfg_q;
  assign drive_low_o = cfg_q.dir & ~cfg_q.val;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_od_pad_reg.sv
module gpio_od_pad_reg
  import gpio_od_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [1:0]    line_in_i,
  output logic [1:0]    line_drive_low_o,
  output logic [1:0]    pullup_dis_o
);
  localparam int unsigned PUD_TOP = PUD_BASE + LINES;

  line_cfg_t  cfg [LINES];
  logic [LINES-1:0] in_sync;
  logic [LINES-1:0] pud_q;

  wire unused_ok = &{1'b0, wdata_i};

  for (genvar k = 0; k < LINES; k++) begin : g_line
    localparam int unsigned B = k * LANE_W;
    gpio_line_ctrl u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .dir_msk_i   (wdata_i[B+OFS_DMSK]),
      .dir_i       (wdata_i[B+OFS_DIR]),
      .val_msk_i   (wdata_i[B+OFS_VMSK]),
      .val_i       (wdata_i[B+OFS_VAL]),
      .cfg_o       (cfg[k]),
      .drive_low_o (line_drive_low_o[k])
    );
  end

  gpio_in_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_in_i),
    .q_o    (in_sync)
  );

  // pull-up disables ignore the masks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pud_q <= '0;
    else if (wr_en_i) pud_q <= wdata_i[PUD_TOP-1:PUD_BASE];
  end
  assign pullup_dis_o = pud_q;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < LINES; k++) begin
      rdata_o[k*LANE_W+OFS_DIR] = cfg[k].dir;
      rdata_o[k*LANE_W+OFS_VAL] = cfg[k].val;
      rdata_o[k*LANE_W+OFS_IN]  = in_sync[k];
    end
    rdata_o[PUD_TOP-1:PUD_BASE] = pud_q;
  end
endmodule

// File: rtl/gpio_od_pad_reg_chk.sv
module gpio_od_pad_reg_chk
  import gpio_od_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [1:0]    line_in_i,
  input logic [1:0]    line_drive_low_o,
  input logic [1:0]    pullup_dis_o
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (line_drive_low_o == 2'b00 && pullup_dis_o == 2'b00));

  assert_pud_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> pullup_dis_o == $past(wdata_i[PUD_BASE+1:PUD_BASE]));

  assert_pud_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pullup_dis_o));

  for (genvar k = 0; k < LINES; k++) begin : g_chk
    localparam int unsigned B = k * LANE_W;

    assert_dir_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wdata_i[B+OFS_DMSK]) |=> $stable(rdata_o[B+OFS_DIR]));

    assert_val_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wdata_i[B+OFS_VMSK]) |=> $stable(rdata_o[B+OFS_VAL]));

    assert_dir_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wdata_i[B+OFS_DMSK]) |=> rdata_o[B+OFS_DIR] == $past(wdata_i[B+OFS_DIR]));

    assert_pull_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wdata_i[B+OFS_DMSK] && wdata_i[B+OFS_DIR] &&
       wdata_i[B+OFS_VMSK] && !wdata_i[B+OFS_VAL]) |=> line_drive_low_o[k]);

    assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wdata_i[B+OFS_DMSK] && !wdata_i[B+OFS_DIR]) |=> !line_drive_low_o[k]);

    assert_mask_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[B+OFS_DMSK] == 1'b0 && rdata_o[B+OFS_VMSK] == 1'b0);

    assert_sync_delay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (SYNC_STAGES == 2 && since_rst >= 2'd2) |-> rdata_o[B+OFS_IN] == $past(line_in_i[k], 2));
  end
endmodule

bind gpio_od_pad_reg gpio_od_pad_reg_chk #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/tb_gpio_od_pad_reg.sv
module tb_gpio_od_pad_reg;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  line_in_i = 2'b11;
  logic [1:0]  line_drive_low_o;
  logic [1:0]  pullup_dis_o;

  int checks = 0;
  int fails  = 0;

  // model
  logic [1:0] m_dir = '0, m_val = '0, m_pud = '0, m_in = '0;

  gpio_od_pad_reg dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] lane(int k, bit dm, bit d, bit vm, bit v);
    logic [31:0] w = '0;
    w[8*k+0] = dm; w[8*k+1] = d; w[8*k+2] = vm; w[8*k+3] = v;
    return w;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    for (int k = 0; k < 2; k++) begin
      w[8*k+1] = m_dir[k]; w[8*k+3] = m_val[k]; w[8*k+4] = m_in[k];
    end
    w[17:16] = m_pud;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    logic [1:0] dl;
    for (int k = 0; k < 2; k++) dl[k] = m_dir[k] & ~m_val[k];
    chk(rdata_o == exp_word(), {req, " rdata"}, rdata_o, exp_word());
    chk(line_drive_low_o == dl, {req, " drive_low"}, 32'(line_drive_low_o), 32'(dl));
    chk(pullup_dis_o == m_pud, {req, " pullup_dis"}, 32'(pullup_dis_o), 32'(m_pud));
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
    for (int k = 0; k < 2; k++) begin
      if (d[8*k+0]) m_dir[k] = d[8*k+1];
      if (d[8*k+2]) m_val[k] = d[8*k+3];
    end
    m_pud = d[17:16];
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk_all("R1 in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    m_in = 2'b11;
    chk_all("R1 after release");
  endtask

  task automatic t_pull_low_clock();
    do_write(lane(0, 1, 1, 1, 0));
    chk(line_drive_low_o == 2'b01, "R4 clock low", 32'(line_drive_low_o), 32'h1);
    chk_all("R4 R7 clock low");
  endtask

  task automatic t_no_mask();
    do_write(lane(0, 0, 0, 0, 1) | lane(1, 0, 1, 0, 1));
    chk_all("R3 no mask");
  endtask

  task automatic t_value_only();
    do_write(lane(0, 0, 0, 1, 1));
    chk(line_drive_low_o[0] == 1'b0, "R6 output high not driven", 32'(line_drive_low_o), 32'h0);
    chk_all("R2 value only");
    do_write(lane(0, 0, 0, 1, 0));
    chk_all("R2 value back low");
  endtask

  task automatic t_data_line();
    do_write(lane(1, 1, 1, 1, 0));
    chk(line_drive_low_o == 2'b11, "R7 data low clock kept", 32'(line_drive_low_o), 32'h3);
    chk_all("R7 data low");
  endtask

  task automatic t_release();
    do_write(lane(1, 1, 0, 0, 1));
    chk(line_drive_low_o == 2'b01, "R5 data released", 32'(line_drive_low_o), 32'h1);
    chk_all("R5 release keeps value");
    do_write(lane(0, 1, 0, 0, 0));
    chk_all("R5 clock released");
  endtask

  task automatic t_pullup();
    do_write(32'h0002_0000);
    chk_all("R8 pud data no mask");
    do_write(32'h0001_0000 | lane(0, 1, 1, 0, 0));
    chk_all("R8 pud clock with mask");
    do_write(lane(0, 1, 0, 0, 0));
    chk_all("R8 pud cleared by write");
  endtask

  task automatic t_sync();
    @(negedge clk_i);
    line_in_i = 2'b01;
    @(negedge clk_i);
    chk_all("R9 one edge old level");
    @(negedge clk_i);
    m_in = 2'b01;
    chk_all("R9 two edges new level");
    line_in_i = 2'b10;
    repeat (2) @(negedge clk_i);
    m_in = 2'b10;
    chk_all("R9 second pattern");
  endtask

  task automatic t_readback_all_ones();
    do_write(32'hFFFF_FFFF);
    chk_all("R10 unassigned and masks read 0");
    do_write(32'h0000_0000);
    chk_all("R10 clear pud only");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pull_low_clock();
    t_no_mask();
    t_value_only();
    t_data_line();
    t_release();
    t_pullup();
    t_sync();
    t_readback_all_ones();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule